// File: doc/BRIEF.md
# Two-Way Instruction Cache with Repeatable Pseudo-Random Replacement

This block is a read-only instruction cache that sits between a fetch unit and a slow memory port. It holds 4 KB in two ways of 64 sets, and each line is 32 bytes (eight 32-bit words). A fetch that hits returns its word on the next cycle. A fetch that misses allocates a line: the block requests the aligned line from memory, takes eight beats in word order, and then returns the requested word. Only one fetch is handled at a time.

When both ways of a set already hold valid lines, an 8-bit linear feedback shift register chooses the victim. It starts from a fixed seed, so the same fetch stream always evicts the same lines. The valid bits are not defined after reset. Software must therefore run the invalidate-all command before it sets the enable input. While the cache is disabled, each fetch goes to memory as a single-word access and nothing is stored.

Top module: `icache2w`

## Requirements
- R1: The address is split into tag = addr[31:11], set = addr[10:5] and word = addr[4:2]. Two lines with the same set and different tags, such as 0x004C and 0x204C, can both be resident, and both then hit.
- R2: A fetch that hits while enabled raises cpu_rsp_valid on the cycle after it is accepted, with the stored word, and makes no memory request.
- R3: A miss while enabled makes one memory request with mem_req_burst=1 and mem_req_addr equal to the fetch address with bits [4:0] cleared. The request is held until it is accepted. The eight beats fill words 0 to 7 in order. The line becomes valid, and the requested word is returned, only after the eighth beat.
- R4: On a miss, way 0 is filled if its line in the set is invalid. Otherwise way 1 is filled if its line is invalid.
- R5: When both ways of the set are valid, the victim is way number lfsr[0]. The 8-bit register starts at 0xA5. Each step shifts it left and feeds lfsr[7]^lfsr[5]^lfsr[4]^lfsr[3] into bit 0. It steps only on a miss where both ways were valid.
- R6: While cache_en=0, each fetch makes one memory request with mem_req_burst=0, with mem_req_addr equal to the fetch address, and returns that single beat. It allocates nothing, so the same address still misses after the cache is enabled.
- R7: A pulse on inv_req while idle holds inv_busy high for exactly 64 cycles, one set per cycle. cpu_req_ready stays low during that time. Afterwards every line misses.
- R8: After reset, cpu_req_ready=1, cpu_rsp_valid=0, mem_req_valid=0 and inv_busy=0.
- R9: Only one fetch is outstanding at a time. cpu_req_ready stays low from the acceptance of a miss or bypass until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en | input | 1 | 1 = caching on, 0 = bypass to memory |
| inv_req | input | 1 | Pulse that starts invalidate-all |
| inv_busy | output | 1 | High while invalidate-all runs |
| cpu_req_valid | input | 1 | Fetch request valid |
| cpu_req_ready | output | 1 | Fetch request can be accepted |
| cpu_req_addr | input | 32 | Fetch byte address, word aligned |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_data | output | 32 | Fetched instruction word |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Line base (burst) or word address (single) |
| mem_req_burst | output | 1 | 1 = eight-beat line read, 0 = one beat |
| mem_beat_valid | input | 1 | Returned data beat valid |
| mem_beat_data | input | 32 | Returned data word |

## Verification
The embedded assertions rely on four conditions at the inputs. cache_en changes only while no fetch is outstanding. inv_req is pulsed only while the block is idle. Memory returns exactly the number of beats requested, in ascending word order. Fetch addresses are word aligned. The testbench keeps to these conditions by changing cache_en and pulsing inv_req only between scenario tasks, after the previous response has arrived. Its memory responder returns beats in order, with idle gaps between some of them. A reference model in the testbench tracks tags, valid bits and its own copy of the register sequence. From these it predicts hit or miss for repeated conflicting fetches to one set.

// File: rtl/icache2w.sv
module icache2w #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SET_W  = 6,
  parameter int WORD_W = 3,
  parameter logic [7:0] LFSR_SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              inv_req,
  output logic              inv_busy,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_burst,
  input  logic              mem_beat_valid,
  input  logic [DATA_W-1:0] mem_beat_data
);
  localparam int SETS  = 1 << SET_W;
  localparam int WORDS = 1 << WORD_W;
  localparam int BO_W  = $clog2(DATA_W / 8);
  localparam int OFF_W = WORD_W + BO_W;
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int LW    = SET_W + WORD_W;
  localparam logic [SET_W-1:0]  LAST_SET  = SET_W'(SETS - 1);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_INV, ST_REQ, ST_BEAT} st_t;

  st_t               st_q;
  logic [SET_W-1:0]  inv_cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              byp_q;
  logic              vic_q;
  logic [WORD_W-1:0] beat_q;
  logic [DATA_W-1:0] hold_q;
  logic [7:0]        lfsr_q;
  logic              rsp_v_q;
  logic [DATA_W-1:0] rsp_d_q;

  logic [SETS-1:0]   vld0_q, vld1_q;
  logic [TAG_W-1:0]  tag0_q [SETS];
  logic [TAG_W-1:0]  tag1_q [SETS];
  logic [DATA_W-1:0] dat0_q [SETS*WORDS];
  logic [DATA_W-1:0] dat1_q [SETS*WORDS];

  wire [SET_W-1:0]  in_set  = cpu_req_addr[OFF_W +: SET_W];
  wire [WORD_W-1:0] in_word = cpu_req_addr[BO_W +: WORD_W];
  wire [TAG_W-1:0]  in_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0]  q_set   = addr_q[OFF_W +: SET_W];
  wire [WORD_W-1:0] q_word  = addr_q[BO_W +: WORD_W];
  wire [TAG_W-1:0]  q_tag   = addr_q[ADDR_W-1 -: TAG_W];

  wire hit0    = vld0_q[in_set] && (tag0_q[in_set] == in_tag);
  wire hit1    = vld1_q[in_set] && (tag1_q[in_set] == in_tag);
  wire hit_any = hit0 | hit1;
  wire both_v  = vld0_q[in_set] & vld1_q[in_set];
  wire vic_sel = !vld0_q[in_set] ? 1'b0 : (!vld1_q[in_set] ? 1'b1 : lfsr_q[0]);
  wire [7:0] lfsr_nxt = {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};

  wire accept   = cpu_req_valid && cpu_req_ready;
  wire fill_hit = (st_q == ST_BEAT) && mem_beat_valid && !byp_q;
  wire fill_end = fill_hit && (beat_q == LAST_WORD);

  assign cpu_req_ready = (st_q == ST_IDLE) && !inv_req;
  assign inv_busy      = (st_q == ST_INV);
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_burst = !byp_q;
  assign mem_req_addr  = byp_q ? addr_q : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign cpu_rsp_valid = rsp_v_q;
  assign cpu_rsp_data  = rsp_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      inv_cnt_q <= '0;
      addr_q    <= '0;
      byp_q     <= 1'b0;
      vic_q     <= 1'b0;
      beat_q    <= '0;
      hold_q    <= '0;
      lfsr_q    <= LFSR_SEED;
      rsp_v_q   <= 1'b0;
      rsp_d_q   <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (inv_req) begin
            st_q      <= ST_INV;
            inv_cnt_q <= '0;
          end else if (accept) begin
            addr_q <= cpu_req_addr;
            if (!cache_en) begin
              byp_q <= 1'b1;
              st_q  <= ST_REQ;
            end else if (hit_any) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= hit0 ? dat0_q[{in_set, in_word}] : dat1_q[{in_set, in_word}];
            end else begin
              byp_q <= 1'b0;
              vic_q <= vic_sel;
              if (both_v) lfsr_q <= lfsr_nxt;
              st_q  <= ST_REQ;
            end
          end
        end
        ST_INV: begin
          inv_cnt_q <= inv_cnt_q + 1'b1;
          if (inv_cnt_q == LAST_SET) st_q <= ST_IDLE;
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            st_q   <= ST_BEAT;
            beat_q <= '0;
          end
        end
        ST_BEAT: begin
          if (mem_beat_valid) begin
            if (byp_q) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= mem_beat_data;
              st_q    <= ST_IDLE;
            end else begin
              if (beat_q == q_word) hold_q <= mem_beat_data;
              beat_q <= beat_q + 1'b1;
              if (beat_q == LAST_WORD) begin
                rsp_v_q <= 1'b1;
                rsp_d_q <= (q_word == LAST_WORD) ? mem_beat_data : hold_q;
                st_q    <= ST_IDLE;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_INV) begin
      vld0_q[inv_cnt_q] <= 1'b0;
      vld1_q[inv_cnt_q] <= 1'b0;
    end
    if (fill_hit) begin
      if (vic_q) dat1_q[{q_set, beat_q}] <= mem_beat_data;
      else       dat0_q[{q_set, beat_q}] <= mem_beat_data;
    end
    if (fill_end) begin
      if (vic_q) begin
        vld1_q[q_set] <= 1'b1;
        tag1_q[q_set] <= q_tag;
      end else begin
        vld0_q[q_set] <= 1'b1;
        tag0_q[q_set] <= q_tag;
      end
    end
  end

  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> !cpu_req_ready); // R7
  AST_INV_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inv_busy) |-> (vld0_q == '0 && vld1_q == '0)); // R7
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cache_en && hit_any) |=> (cpu_rsp_valid && !mem_req_valid)); // R2
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_burst) |-> (mem_req_addr[OFF_W-1:0] == '0)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3
  AST_VALID_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_BEAT) && (beat_q != LAST_WORD)) |=> ($stable(vld0_q) && $stable(vld1_q))); // R3
  AST_BYPASS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_BEAT) && byp_q) |=> ($stable(vld0_q) && $stable(vld1_q))); // R6
  AST_VICTIM_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cache_en && !hit_any && !vld0_q[in_set]) |=> (vic_q == 1'b0)); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || (st_q == ST_BEAT)) |-> !cpu_req_ready); // R9
endmodule

// File: tb/tb_icache2w.sv
module tb_icache2w;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b0;
  logic        inv_req = 1'b0;
  logic        inv_busy;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic [31:0] cpu_req_addr = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_req_burst;
  logic        mem_beat_valid = 1'b0;
  logic [31:0] mem_beat_data = '0;

  always #4 clk = ~clk;

  icache2w dut (.*);

  int checks = 0, errors = 0;
  int mem_reqs = 0, beats = 0;
  logic [31:0] last_addr = '0;
  logic        last_burst = 1'b0;

  logic        mv [2][64];
  logic [20:0] mt [2][64];
  logic [7:0]  mlfsr = 8'hA5;

  function automatic logic [31:0] memw(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      mem_reqs++;
      last_addr  <= mem_req_addr;
      last_burst <= mem_req_burst;
    end
    if (mem_beat_valid) beats++;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        automatic logic [31:0] a = mem_req_addr;
        automatic int n = mem_req_burst ? 8 : 1;
        @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < n; i++) begin
          if (i % 3 == 1) @(negedge clk);
          mem_beat_valid = 1'b1;
          mem_beat_data  = memw(a + 32'(4 * i));
          @(negedge clk);
          mem_beat_valid = 1'b0;
        end
      end
    end
  end

  function automatic bit model_access(input logic [31:0] a);
    automatic logic [5:0]  s = a[10:5];
    automatic logic [20:0] t = a[31:11];
    automatic int w;
    if (mv[0][s] && mt[0][s] == t) return 1'b1;
    if (mv[1][s] && mt[1][s] == t) return 1'b1;
    if (!mv[0][s]) w = 0;
    else if (!mv[1][s]) w = 1;
    else begin
      w = mlfsr[0];
      mlfsr = {mlfsr[6:0], mlfsr[7] ^ mlfsr[5] ^ mlfsr[4] ^ mlfsr[3]};
    end
    mv[w][s] = 1'b1;
    mt[w][s] = t;
    return 1'b0;
  endfunction

  task automatic fetch(input logic [31:0] a, input bit exp_hit, input string req);
    automatic int r0 = mem_reqs;
    automatic int b0 = beats;
    automatic int lat = 0;
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_addr  = a;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid && lat < 300) begin
      lat++;
      @(negedge clk);
    end
    chk(cpu_rsp_valid, req, {31'd0, cpu_rsp_valid}, 32'd1);
    chk(cpu_rsp_data == memw(a), req, cpu_rsp_data, memw(a));
    if (exp_hit) begin
      chk(mem_reqs == r0 && lat == 0, req, 32'(mem_reqs - r0), 32'd0);
    end else if (cache_en) begin
      chk(mem_reqs == r0 + 1 && last_burst, req, 32'(mem_reqs - r0), 32'd1);
      chk(last_addr == {a[31:5], 5'd0}, req, last_addr, {a[31:5], 5'd0});
      chk(beats - b0 == 8, req, 32'(beats - b0), 32'd8);
    end else begin
      chk(mem_reqs == r0 + 1 && !last_burst, req, {31'd0, last_burst}, 32'd0);
      chk(last_addr == a, req, last_addr, a);
    end
  endtask

  task automatic do_invalidate(input string req);
    automatic int busy = 0;
    automatic bit rdy_seen = 1'b0;
    @(negedge clk);
    inv_req = 1'b1;
    @(negedge clk);
    inv_req = 1'b0;
    while (inv_busy && busy < 500) begin
      busy++;
      if (cpu_req_ready) rdy_seen = 1'b1;
      @(negedge clk);
    end
    chk(busy == 64, req, 32'(busy), 32'd64);
    chk(!rdy_seen, req, {31'd0, rdy_seen}, 32'd0);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 64; s++) mv[w][s] = 1'b0;
  endtask

  task automatic t_reset;
    chk(cpu_req_ready && !cpu_rsp_valid && !mem_req_valid && !inv_busy, "R8",
        {28'd0, cpu_req_ready, cpu_rsp_valid, mem_req_valid, inv_busy}, 32'h8);
  endtask

  task automatic t_bypass;
    cache_en = 1'b0;
    fetch(32'h0000_0100, 1'b0, "R6 bypass first");
    fetch(32'h0000_0100, 1'b0, "R6 bypass again");
    fetch(32'h0000_0414, 1'b0, "R6 bypass other");
  endtask

  task automatic t_fill_and_hit;
    cache_en = 1'b1;
    void'(model_access(32'h0000_004C));
    fetch(32'h0000_004C, 1'b0, "R3 miss fill");
    void'(model_access(32'h0000_0040));
    fetch(32'h0000_0040, 1'b1, "R2 hit word0");
    void'(model_access(32'h0000_005C));
    fetch(32'h0000_005C, 1'b1, "R2 hit word7");
    void'(model_access(32'h0000_307C));
    fetch(32'h0000_307C, 1'b0, "R3 requested last word");
  endtask

  task automatic t_two_ways;
    void'(model_access(32'h0000_204C));
    fetch(32'h0000_204C, 1'b0, "R4 second way fill");
    void'(model_access(32'h0000_004C));
    fetch(32'h0000_004C, 1'b1, "R1 first tag resident");
    void'(model_access(32'h0000_2048));
    fetch(32'h0000_2048, 1'b1, "R1 second tag resident");
    void'(model_access(32'h0000_0100));
    fetch(32'h0000_0100, 1'b0, "R6 bypass left no line");
  endtask

  task automatic t_replace;
    automatic logic [31:0] tags [5] = '{32'h0, 32'h1, 32'h5, 32'h4, 32'h6};
    for (int i = 0; i < 24; i++) begin
      automatic logic [31:0] a = (tags[(i * 3 + i / 5) % 5] << 11) | 32'h44;
      automatic bit h = model_access(a);
      fetch(a, h, "R5 replacement order");
    end
  endtask

  task automatic t_reinvalidate;
    do_invalidate("R7 second invalidate");
    void'(model_access(32'h0000_004C));
    fetch(32'h0000_004C, 1'b0, "R7 miss after invalidate");
    void'(model_access(32'h0000_0050));
    fetch(32'h0000_0050, 1'b1, "R2 hit after refill");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    do_invalidate("R7 first invalidate");
    t_bypass();
    t_fill_and_hit();
    t_two_ways();
    t_replace();
    t_reinvalidate();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule